// File: doc/BRIEF.md
# NAND Flash Device Bus Front-End

This block is the device-side logic of a byte-wide NAND flash memory. It runs on a fast system clock and samples the asynchronous pins. These are the command and address strobes, the active-low chip, write, read and write-protect enables, and an 8-bit data port. Commands, address bytes and write data all share the one byte port. The levels of the command and address strobes at each write-enable rising edge decide which register takes the byte.

Data written with neither strobe high goes into a small page buffer at the current column, and the column counter then advances. Each read-enable falling edge queues the byte at the current column onto the output port, which shows it a fixed number of clocks later, and the column counter advances again. Three confirm opcodes start a busy period. Its length is set per operation by a parameter, and during it the open-drain ready/busy line is pulled low. While busy, the chip enable is disregarded. A deselected, idle device reports standby. The write-protect pin suppresses program and erase confirms.

Top module: `nand_bus_front`

## Requirements
- R1: Every pin passes through a two-flop synchronizer. A write strobe is taken at the first clock edge that samples WE# high after it was low, and it acts two edges later. When the command strobe is high (it takes priority over the address strobe), the byte goes into `cmd_q`.
- R2: The first address-strobe write after any non-address write starts a new sequence: `addr_q` becomes that byte in bits [7:0] with all other bits zero, and the column counter clears. Each following address byte k (k = 1, 2, ...) lands in bits [8k+7:8k]. Bytes beyond ADDR_BYTES are ignored.
- R3: A write with both strobes low stores the byte at the current column and increments the column, which wraps modulo PAGE_BYTES.
- R4: An RE# falling edge first sampled at edge n increments the column at edge n+2. From edge n+2+ACCESS_DLY, `io_out` holds the byte that was at the old column.
- R5: Confirm bytes 0x30 (read), 0x10 (program) and 0xD0 (erase) drive `rb_pull` high from the second edge after the strobe sample, for exactly T_READ, T_PROG or T_ERASE clocks respectively.
- R6: While busy, CE# is disregarded: `standby` stays low, the busy period runs to completion, and write and read strobes have no effect.
- R7: `standby` is high when synchronized CE# is high and the device is not busy. `io_oe` is high only when selected, ready and synchronized RE# is low. Both follow the pins one edge after the first sample. After reset, `standby` is 1 and `rb_pull`, `io_oe`, `cmd_q`, `addr_q`, `col_q` and `io_out` are 0.
- R8: When synchronized WP# is low, program (0x10) and erase (0xD0) confirms start no busy period. A read confirm is still accepted.
- R9: While CE# is high and the device is ready, write and read strobes change no register.
- R10: The ready/busy output is a pull-low enable (`rb_pull`). The line is pulled low exactly while this enable is 1 and is otherwise released, never driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cle | input | 1 | Command strobe level |
| ale | input | 1 | Address strobe level |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| re_n | input | 1 | Read enable, active low |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Byte port input |
| io_out | output | 8 | Byte port output data |
| io_oe | output | 1 | Byte port output enable |
| rb_pull | output | 1 | Ready/busy pull-low enable |
| standby | output | 1 | Low-power standby status |
| cmd_q | output | 8 | Latched command byte |
| addr_q | output | 8*ADDR_BYTES | Latched address bytes |
| col_q | output | log2(PAGE_BYTES) | Column address counter |

## Verification
The bench builds the block with a 16-byte page, three address bytes, an access delay of two clocks and busy lengths of 5, 9 and 13 clocks. The small page lets eighteen data writes and eighteen reads cross the column wrap. The short address width lets a fourth address byte exercise the overflow rule. The distinct busy lengths let one run tell the three operations apart, and the short durations leave room to raise CE# and to try strobes in the middle of a busy period.

// File: rtl/nfb_pkg.sv
package nfb_pkg;
  localparam logic [7:0] OP_READ_GO  = 8'h30;
  localparam logic [7:0] OP_PROG_GO  = 8'h10;
  localparam logic [7:0] OP_ERASE_GO = 8'hD0;

  typedef enum logic [1:0] {LAT_CMD, LAT_ADDR, LAT_DATA} lat_kind_e;

  // command strobe wins over address strobe
  function automatic lat_kind_e classify(input logic cle, input logic ale);
    if (cle)      return LAT_CMD;
    else if (ale) return LAT_ADDR;
    else          return LAT_DATA;
  endfunction

  // busy length for a command byte; 0 means no operation starts
  function automatic int unsigned busy_len(input logic [7:0] op, input logic wp_n,
                                           input int unsigned t_rd,
                                           input int unsigned t_pg,
                                           input int unsigned t_er);
    if (op == OP_READ_GO)               return t_rd;
    else if (op == OP_PROG_GO  && wp_n) return t_pg;
    else if (op == OP_ERASE_GO && wp_n) return t_er;
    else                                return 0;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/nfb_sync.sv
module nfb_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST;
      q    <= RST;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/nfb_busy.sv
module nfb_busy #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= len - 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/nfb_rdpipe.sv
module nfb_rdpipe #(
  parameter int DLY = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_v,
  input  logic [7:0] in_d,
  output logic [7:0] out_d
);
  logic       v [DLY];
  logic [7:0] d [DLY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v[0] <= 1'b0;
      d[0] <= '0;
    end else begin
      v[0] <= in_v;
      d[0] <= in_d;
    end
  end

  for (genvar i = 1; i < DLY; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v[i] <= 1'b0;
        d[i] <= '0;
      end else begin
        v[i] <= v[i-1];
        d[i] <= d[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_d <= '0;
    else if (v[DLY-1])  out_d <= d[DLY-1];
  end
endmodule

// File: rtl/nand_bus_front.sv
module nand_bus_front
  import nfb_pkg::*;
#(
  parameter int PAGE_BYTES = 64,
  parameter int ADDR_BYTES = 4,
  parameter int ACCESS_DLY = 3,
  parameter int T_READ     = 25,
  parameter int T_PROG     = 200,
  parameter int T_ERASE    = 1000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cle,
  input  logic                        ale,
  input  logic                        ce_n,
  input  logic                        we_n,
  input  logic                        re_n,
  input  logic                        wp_n,
  input  logic [7:0]                  io_in,
  output logic [7:0]                  io_out,
  output logic                        io_oe,
  output logic                        rb_pull,
  output logic                        standby,
  output logic [7:0]                  cmd_q,
  output logic [8*ADDR_BYTES-1:0]     addr_q,
  output logic [$clog2(PAGE_BYTES)-1:0] col_q
);
  localparam int CW    = $clog2(PAGE_BYTES);
  localparam int AW    = 8 * ADDR_BYTES;
  localparam int IW    = $clog2(ADDR_BYTES + 1);
  localparam int BW    = $clog2(max3(T_READ, T_PROG, T_ERASE) + 1);
  localparam int PW    = 14;
  localparam logic [PW-1:0] PIN_IDLE = {2'b00, 4'b1111, 8'h00};

  // synchronized pins
  logic [PW-1:0] pin_s;
  nfb_sync #(.W(PW), .RST(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cle, ale, ce_n, we_n, re_n, wp_n, io_in}), .q(pin_s)
  );

  logic       cle_s, ale_s, ce_s, we_s, re_s, wp_s;
  logic [7:0] io_s;
  assign {cle_s, ale_s, ce_s, we_s, re_s, wp_s, io_s} = pin_s;

  logic we_d, re_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_d <= 1'b1;
      re_d <= 1'b1;
    end else begin
      we_d <= we_s;
      re_d <= re_s;
    end
  end

  // named events
  logic busy;
  logic we_rise, re_fall, act;
  logic cmd_wr, addr_wr, data_wr, rd_go, addr_new, op_start;
  lat_kind_e kind;
  int unsigned op_len;

  assign we_rise  = we_s & ~we_d;
  assign re_fall  = re_d & ~re_s;
  assign act      = ~ce_s & ~busy;
  assign kind     = classify(cle_s, ale_s);
  assign cmd_wr   = act & we_rise & (kind == LAT_CMD);
  assign addr_wr  = act & we_rise & (kind == LAT_ADDR);
  assign data_wr  = act & we_rise & (kind == LAT_DATA);
  assign rd_go    = act & re_fall & ~we_rise;
  assign op_len   = busy_len(io_s, wp_s, T_READ, T_PROG, T_ERASE);
  assign op_start = cmd_wr & (op_len != 0);

  // address sequencing
  logic          in_addr;
  logic [IW-1:0] idx;
  assign addr_new = addr_wr & ~in_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      addr_q  <= '0;
      idx     <= '0;
      in_addr <= 1'b0;
    end else begin
      if (cmd_wr) cmd_q <= io_s;
      if (cmd_wr || data_wr) in_addr <= 1'b0;
      if (addr_new) begin
        addr_q  <= {{(AW-8){1'b0}}, io_s};
        idx     <= IW'(1);
        in_addr <= 1'b1;
      end else if (addr_wr && (int'(idx) < ADDR_BYTES)) begin
        addr_q[idx*8 +: 8] <= io_s;
        idx                <= idx + 1'b1;
      end
    end
  end

  // page buffer and column counter
  logic [7:0] page_mem [PAGE_BYTES];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) page_mem[i] <= '0;
    end else begin
      if (data_wr) page_mem[col_q] <= io_s;
      if (addr_new)                col_q <= '0;
      else if (data_wr || rd_go)   col_q <= col_q + 1'b1;
    end
  end

  nfb_rdpipe #(.DLY(ACCESS_DLY)) u_rdpipe (
    .clk(clk), .rst_n(rst_n), .in_v(rd_go), .in_d(page_mem[col_q]), .out_d(io_out)
  );

  nfb_busy #(.CNT_W(BW)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(op_start), .len(BW'(op_len)), .busy(busy)
  );

  assign rb_pull = busy;
  assign standby = ce_s & ~busy;
  assign io_oe   = ~ce_s & ~re_s & ~busy;
endmodule

// File: rtl/nfb_chk.sv
module nfb_chk
  import nfb_pkg::*;
#(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_wr,
  input logic          data_wr,
  input logic          rd_go,
  input logic          addr_new,
  input logic          op_start,
  input logic          busy,
  input logic          wp_s,
  input logic [7:0]    io_s,
  input logic [7:0]    cmd_q,
  input logic [CW-1:0] col_q
);
  // R1
  cmd_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> cmd_q == $past(io_s));
  // R2
  addr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_new |=> col_q == '0);
  // R3
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr || rd_go) && !addr_new |=> col_q == CW'($past(col_q) + 1'b1));
  // R5
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(op_start));
  // R8
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !wp_s && (io_s == OP_PROG_GO || io_s == OP_ERASE_GO) |=> !busy);
endmodule

bind nand_bus_front nfb_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr), .rd_go(rd_go),
  .addr_new(addr_new), .op_start(op_start), .busy(busy), .wp_s(wp_s),
  .io_s(io_s), .cmd_q(cmd_q), .col_q(col_q)
);

// File: tb/nand_bus_front_tb.sv
module nand_bus_front_tb;
  localparam int PB = 16, AB = 3, D = 2, TR = 5, TP = 9, TE = 13;

  logic clk = 0, rst_n = 0;
  logic cle = 0, ale = 0, ce_n = 1, we_n = 1, re_n = 1, wp_n = 1;
  logic [7:0] io_in = 0;
  logic [7:0] io_out, cmd_q;
  logic io_oe, rb_pull, standby;
  logic [8*AB-1:0] addr_q;
  logic [3:0] col_q;

  always #5 clk = ~clk;

  nand_bus_front #(.PAGE_BYTES(PB), .ADDR_BYTES(AB), .ACCESS_DLY(D),
                   .T_READ(TR), .T_PROG(TP), .T_ERASE(TE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .ce_n(ce_n), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .rb_pull(rb_pull), .standby(standby), .cmd_q(cmd_q), .addr_q(addr_q), .col_q(col_q)
  );

  int checks = 0, fails = 0;
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: pin history, one entry per clock edge
  logic [13:0] hist [$];
  logic [7:0]  m_cmd, m_io;
  logic [23:0] m_addr;
  logic [7:0]  m_buf [PB];
  int m_idx, m_col, m_cnt, cyc;
  bit m_inaddr, m_busy, m_stby, m_oe;
  logic [7:0] due [int];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {14'h0F00, 14'h0F00, 14'h0F00};
      m_cmd = 0; m_io = 0; m_addr = 0; m_idx = 0; m_col = 0; m_cnt = 0; cyc = 0;
      m_inaddr = 0; m_busy = 0; m_stby = 1; m_oe = 0;
      foreach (m_buf[i]) m_buf[i] = 0;
      due.delete();
    end else begin
      logic [13:0] cur, old;
      bit act, wrise, rfall, was_busy;
      int len;
      cyc++;
      cur = hist[hist.size()-2];
      old = hist[hist.size()-3];
      was_busy = m_busy;
      act   = !cur[11] && !was_busy;
      wrise = !old[10] && cur[10];
      rfall = old[9] && !cur[9];
      len = 0;
      if (act && wrise) begin
        if (cur[13]) begin
          m_cmd = cur[7:0]; m_inaddr = 0;
          if (cur[7:0] == 8'h30) len = TR;
          if (cur[7:0] == 8'h10 && cur[8]) len = TP;
          if (cur[7:0] == 8'hD0 && cur[8]) len = TE;
        end else if (cur[12]) begin
          if (!m_inaddr) begin
            m_addr = {16'h0, cur[7:0]}; m_idx = 1; m_col = 0; m_inaddr = 1;
          end else if (m_idx < AB) begin
            m_addr[m_idx*8 +: 8] = cur[7:0]; m_idx++;
          end
        end else begin
          m_buf[m_col] = cur[7:0]; m_col = (m_col + 1) % PB; m_inaddr = 0;
        end
      end else if (act && rfall) begin
        due[cyc + D] = m_buf[m_col];
        m_col = (m_col + 1) % PB;
      end
      if (len != 0) begin m_busy = 1; m_cnt = len - 1; end
      else if (m_busy) begin
        if (m_cnt == 0) m_busy = 0; else m_cnt--;
      end
      if (due.exists(cyc)) begin m_io = due[cyc]; due.delete(cyc); end
      hist.push_back({cle, ale, ce_n, we_n, re_n, wp_n, io_in});
      void'(hist.pop_front());
      cur = hist[hist.size()-2];
      m_stby = cur[11] && !m_busy;
      m_oe   = !cur[11] && !cur[9] && !m_busy;
    end
  end

  // cycle-by-cycle comparison and busy-run measurement
  int run = 0, last_run = 0, wd = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 cmd_q", cmd_q, m_cmd);
      chk("R2 addr_q", addr_q, m_addr);
      chk("R3 col_q", col_q, m_col);
      chk("R4 io_out", io_out, m_io);
      chk("R5 rb_pull", rb_pull, m_busy);
      chk("R7 standby", standby, m_stby);
      chk("R7 io_oe", io_oe, m_oe);
      if (rb_pull) run++;
      else if (run != 0) begin last_run = run; run = 0; end
    end
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask
  task automatic wr(input logic c, input logic a, input logic [7:0] b);
    cle = c; ale = a; io_in = b; we_n = 0; step(3);
    we_n = 1; step(3); cle = 0; ale = 0;
  endtask
  task automatic rd();
    re_n = 0; step(3); re_n = 1; step(3);
  endtask
  task automatic wait_ready();
    step(3);
    for (int i = 0; i < 2000 && rb_pull; i++) step(1);
    step(2);
  endtask

  initial begin
    int c0;
    step(2);
    chk("R7 reset standby", standby, 1);
    chk("R10 reset rb_pull", rb_pull, 0);
    rst_n = 1;
    step(2);
    ce_n = 0; step(3);
    // program setup, address with one extra byte, data across wrap
    wr(1, 0, 8'h80);
    wr(0, 1, 8'h11); wr(0, 1, 8'h22); wr(0, 1, 8'h33); wr(0, 1, 8'h44); // R2 extra byte
    chk("R2 addr overflow", addr_q, 24'h332211);
    for (int i = 0; i < 18; i++) wr(0, 0, 8'hA0 + 8'(i));              // R3 wrap
    chk("R3 col wrap", col_q, 2);
    wr(1, 0, 8'h10);                                                   // R5 program
    ce_n = 1; step(2);
    chk("R6 standby while busy", standby, 0);
    chk("R10 pull while busy", rb_pull, 1);
    ce_n = 0; c0 = col_q;
    wr(0, 0, 8'h5A);                                                   // R6 ignored
    chk("R6 col during busy", col_q, c0);
    wait_ready();
    chk("R5 program length", last_run, TP);
    // write protect blocks program and erase
    wp_n = 0; step(3);
    wr(1, 0, 8'h60); wr(0, 1, 8'h01);
    wr(1, 0, 8'hD0); step(2);
    chk("R8 erase blocked", rb_pull, 0);
    wr(1, 0, 8'h10); step(2);
    chk("R8 program blocked", rb_pull, 0);
    wr(1, 0, 8'h30); wait_ready();
    chk("R8 read allowed", last_run, TR);
    wp_n = 1; step(3);
    wr(1, 0, 8'hD0); wait_ready();
    chk("R5 erase length", last_run, TE);
    // read back the page from column 0
    wr(1, 0, 8'h00);
    wr(0, 1, 8'h00); wr(0, 1, 8'h07); wr(0, 1, 8'h09);
    chk("R2 column cleared", col_q, 0);
    wr(1, 0, 8'h30); wait_ready();
    chk("R5 read length", last_run, TR);
    for (int i = 0; i < 18; i++) begin
      rd();
      chk("R4 read byte", io_out, (i < 16) ? (i < 2 ? 8'hB0 + 8'(i) : 8'hA0 + 8'(i)) : 8'hB0 + 8'(i - 16));
    end
    // standby ignores strobes
    ce_n = 1; step(3);
    chk("R7 standby high", standby, 1);
    c0 = col_q;
    wr(0, 0, 8'h77); rd(); wr(1, 0, 8'h30); step(2);
    chk("R9 col in standby", col_q, c0);
    chk("R9 cmd in standby", cmd_q, 8'h30);
    chk("R9 no busy in standby", rb_pull, 0);
    step(4);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule